// File: doc/BRIEF.md
# Packet Slot Ring Stream Injector

The block keeps complete packets in a ring of equal-sized slots and replays each stored packet as an AXI4-Stream packet. A producer hands over one packet at a time, one byte per cycle. It marks the final byte and gives the source port number with it. The block records the byte count and the port for that slot. It then frees the producer to send the next packet into the following slot.

On the stream side the block emits the oldest stored packet beat by beat. Bytes fill the lanes from lane 0 upward, and the last beat may be partial. The first beat of every packet carries a metadata word in tuser: the length, the source port, and a default destination equal to the source. All later beats carry zero in tuser.

If the producer begins a packet while the slot it targets still holds an unsent packet, the whole packet is thrown away and the ring stays where it was. A packet longer than a slot is also thrown away. After the final beat of a packet, the block leaves one idle cycle in which it frees the slot and moves on to the next one.

Top module: `pkt_slot_streamer`

## Requirements
- R1: While reset is applied and in the cycles after it, m_tvalid, m_tlast and m_tuser are low. Every slot is empty and both ring positions are at slot 0, so the first packet written after reset is the first one played out.
- R2: Beat k of a packet carries packet byte k*DATA_BYTES+i on lane i, where lane i is bits [8i+7:8i] of m_tdata. Bytes keep the order in which they were written.
- R3: m_tkeep has bit i set exactly when lane i holds a packet byte. Every beat except the last has all bits set. The last beat has bits 0..n-1 set, where n = length - k*DATA_BYTES.
- R4: A packet of L bytes takes ceil(L/DATA_BYTES) beats, and m_tlast is high on the final beat only.
- R5: On the first beat, m_tuser[15:0] is the length in bytes, m_tuser[23:16] is the source port given with the final written byte, and m_tuser[31:24] repeats the source port as the default destination.
- R6: m_tuser is zero on every beat after the first. While m_tvalid is low, m_tuser, m_tlast and m_tkeep are zero.
- R7: While m_tvalid is high and m_tready is low, the current beat (m_tdata, m_tkeep, m_tlast, m_tuser) is held unchanged and m_tvalid stays high.
- R8: The cycle after the final beat is accepted, m_tvalid is low. If the next slot already holds a packet, its first beat appears in the cycle after that.
- R9: A packet whose first byte arrives while the slot at the write position is occupied is discarded whole. The write position does not advance, so the next accepted packet lands in that same slot once it is freed.
- R10: Packets are played out in the order they were accepted, and the ring wraps from slot NUM_SLOTS-1 to slot 0.
- R11: A packet longer than SLOT_BYTES is discarded whole, and the write position does not advance. A packet of exactly SLOT_BYTES is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through an internal synchronizer |
| in_valid | input | 1 | A packet byte is present this cycle |
| in_byte | input | 8 | Packet byte |
| in_last | input | 1 | This byte ends the packet |
| in_port | input | 8 | Source port, sampled with the final byte |
| m_tdata | output | DATA_BYTES*8 | Stream data, lane 0 in the low byte |
| m_tkeep | output | DATA_BYTES | One bit per lane holding a packet byte |
| m_tuser | output | 32 | First-beat metadata: length, source, destination |
| m_tvalid | output | 1 | Beat present |
| m_tlast | output | 1 | Final beat of the packet |
| m_tready | input | 1 | Receiver accepts the beat |

## Verification
A stale or wrong slot length shows on the very first beat of the packet: the length field of m_tuser is wrong, and m_tlast lands on the wrong beat. A write position that moves when it should not strands a packet in a slot that the reader never visits, so the expected packet never appears and the stream stays idle. A slot that is not freed, or a read position that does not advance, replays the old packet right after the one-cycle gap. A wrong byte offset shows as wrong lane contents on the next accepted beat.

// File: rtl/pss_pkg.sv
`timescale 1ns/1ps
package pss_pkg;
  localparam int TUSER_W     = 32;
  localparam int LEN_FIELD_W = 16;
  localparam int PORT_W      = 8;

  typedef enum logic [1:0] {
    RD_IDLE = 2'd0,
    RD_SEND = 2'd1,
    RD_GAP  = 2'd2
  } rd_state_e;
endpackage

// File: rtl/pss_reset_sync.sv
`timescale 1ns/1ps
module pss_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_sync = stage2_q;
endmodule

// File: rtl/pss_slot_store.sv
`timescale 1ns/1ps
module pss_slot_store
  import pss_pkg::*;
#(
  parameter int NUM_SLOTS  = 32,
  parameter int SLOT_BYTES = 2048,
  parameter int DATA_BYTES = 64
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [$clog2(NUM_SLOTS)+$clog2(SLOT_BYTES/DATA_BYTES)-1:0] wr_addr,
  input  logic [$clog2(DATA_BYTES)-1:0]   wr_lane,
  input  logic [7:0]                      wr_byte,
  input  logic                            commit_en,
  input  logic [$clog2(NUM_SLOTS)-1:0]    commit_idx,
  input  logic [$clog2(SLOT_BYTES+1)-1:0] commit_len,
  input  logic [PORT_W-1:0]               commit_port,
  input  logic                            clr_en,
  input  logic [$clog2(NUM_SLOTS)-1:0]    clr_idx,
  input  logic [$clog2(NUM_SLOTS)+$clog2(SLOT_BYTES/DATA_BYTES)-1:0] rd_addr,
  input  logic [$clog2(NUM_SLOTS)-1:0]    rd_idx,
  output logic [DATA_BYTES*8-1:0]         rd_data,
  output logic [$clog2(SLOT_BYTES+1)-1:0] rd_len,
  output logic [PORT_W-1:0]               rd_port,
  output logic [NUM_SLOTS-1:0]            occ
);
  localparam int SLOT_WORDS = SLOT_BYTES / DATA_BYTES;
  localparam int DEPTH      = NUM_SLOTS * SLOT_WORDS;
  localparam int LEN_W      = $clog2(SLOT_BYTES + 1);
  localparam int BUS_W      = DATA_BYTES * 8;

  logic [BUS_W-1:0]  mem_q  [DEPTH];
  logic [LEN_W-1:0]  len_q  [NUM_SLOTS];
  logic [PORT_W-1:0] port_q [NUM_SLOTS];

  // Byte-lane write into the word array; storage carries no reset.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_q[wr_addr][wr_lane*8 +: 8] <= wr_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (commit_en) begin
      port_q[commit_idx] <= commit_port;
    end
  end

  // Nonzero length marks a slot as holding an unsent packet.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        len_q[i] <= '0;
      end
    end else begin
      if (commit_en) begin
        len_q[commit_idx] <= commit_len;
      end
      if (clr_en) begin
        len_q[clr_idx] <= '0;
      end
    end
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_occ
    assign occ[g] = (len_q[g] != '0);
  end

  assign rd_data = mem_q[rd_addr];
  assign rd_len  = len_q[rd_idx];
  assign rd_port = port_q[rd_idx];
endmodule

// File: rtl/pss_slot_writer.sv
`timescale 1ns/1ps
module pss_slot_writer
  import pss_pkg::*;
#(
  parameter int NUM_SLOTS  = 32,
  parameter int SLOT_BYTES = 2048,
  parameter int DATA_BYTES = 64
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            in_valid,
  input  logic [7:0]                      in_byte,
  input  logic                            in_last,
  input  logic [PORT_W-1:0]               in_port,
  input  logic [NUM_SLOTS-1:0]            occ,
  output logic                            wr_en,
  output logic [$clog2(NUM_SLOTS)+$clog2(SLOT_BYTES/DATA_BYTES)-1:0] wr_addr,
  output logic [$clog2(DATA_BYTES)-1:0]   wr_lane,
  output logic [7:0]                      wr_byte,
  output logic                            commit_en,
  output logic [$clog2(NUM_SLOTS)-1:0]    commit_idx,
  output logic [$clog2(SLOT_BYTES+1)-1:0] commit_len,
  output logic [PORT_W-1:0]               commit_port
);
  localparam int PTR_W  = $clog2(NUM_SLOTS);
  localparam int LANE_W = $clog2(DATA_BYTES);
  localparam int WORD_W = $clog2(SLOT_BYTES / DATA_BYTES);
  localparam int LEN_W  = $clog2(SLOT_BYTES + 1);

  logic [PTR_W-1:0] ptr_q, ptr_n, ptr_inc;
  logic [LEN_W-1:0] cnt_q, cnt_n, cnt_cur;
  logic             busy_q, busy_n;
  logic             drop_q, drop_n;
  logic             first_byte, slot_full, drop_cur, drop_eff;
  logic             state_en;

  assign ptr_inc    = (ptr_q == PTR_W'(NUM_SLOTS - 1)) ? '0 : ptr_q + PTR_W'(1);
  assign first_byte = !busy_q;
  assign cnt_cur    = first_byte ? '0 : cnt_q;
  assign slot_full  = (cnt_cur >= LEN_W'(SLOT_BYTES));
  // The occupancy decision is taken once, on the first byte.
  assign drop_cur   = first_byte ? occ[ptr_q] : drop_q;
  assign drop_eff   = drop_cur | slot_full;

  assign wr_en       = in_valid && !drop_eff;
  assign wr_addr     = {ptr_q, cnt_cur[LANE_W +: WORD_W]};
  assign wr_lane     = cnt_cur[LANE_W-1:0];
  assign wr_byte     = in_byte;
  assign commit_en   = in_valid && in_last && !drop_eff;
  assign commit_idx  = ptr_q;
  assign commit_len  = cnt_cur + LEN_W'(1);
  assign commit_port = in_port;
  assign state_en    = in_valid;

  always_comb begin
    ptr_n  = ptr_q;
    cnt_n  = cnt_q;
    busy_n = busy_q;
    drop_n = drop_q;
    if (in_last) begin
      busy_n = 1'b0;
      drop_n = 1'b0;
      cnt_n  = '0;
      if (!drop_eff) begin
        ptr_n = ptr_inc;
      end
    end else begin
      busy_n = 1'b1;
      drop_n = drop_eff;
      cnt_n  = slot_full ? cnt_cur : cnt_cur + LEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      drop_q <= 1'b0;
    end else if (state_en) begin
      ptr_q  <= ptr_n;
      cnt_q  <= cnt_n;
      busy_q <= busy_n;
      drop_q <= drop_n;
    end
  end
endmodule

// File: rtl/pss_beat_reader.sv
`timescale 1ns/1ps
module pss_beat_reader
  import pss_pkg::*;
#(
  parameter int NUM_SLOTS  = 32,
  parameter int SLOT_BYTES = 2048,
  parameter int DATA_BYTES = 64
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_SLOTS-1:0]            occ,
  input  logic [$clog2(SLOT_BYTES+1)-1:0] rd_len,
  input  logic [PORT_W-1:0]               rd_port,
  input  logic [DATA_BYTES*8-1:0]         rd_data,
  output logic [$clog2(NUM_SLOTS)-1:0]    rd_idx,
  output logic [$clog2(NUM_SLOTS)+$clog2(SLOT_BYTES/DATA_BYTES)-1:0] rd_addr,
  output logic                            clr_en,
  output logic [$clog2(NUM_SLOTS)-1:0]    clr_idx,
  output logic [DATA_BYTES*8-1:0]         m_tdata,
  output logic [DATA_BYTES-1:0]           m_tkeep,
  output logic [TUSER_W-1:0]              m_tuser,
  output logic                            m_tvalid,
  output logic                            m_tlast,
  input  logic                            m_tready
);
  localparam int PTR_W  = $clog2(NUM_SLOTS);
  localparam int LANE_W = $clog2(DATA_BYTES);
  localparam int WORD_W = $clog2(SLOT_BYTES / DATA_BYTES);
  localparam int LEN_W  = $clog2(SLOT_BYTES + 1);

  rd_state_e        state_q, state_n;
  logic [PTR_W-1:0] ptr_q, ptr_n, ptr_inc;
  logic [LEN_W-1:0] off_q, off_n, remaining;
  logic             sending, final_beat, first_beat;
  logic             ptr_en, off_en;

  assign ptr_inc    = (ptr_q == PTR_W'(NUM_SLOTS - 1)) ? '0 : ptr_q + PTR_W'(1);
  assign sending    = (state_q == RD_SEND);
  assign remaining  = rd_len - off_q;
  assign final_beat = (remaining <= LEN_W'(DATA_BYTES));
  assign first_beat = (off_q == '0);

  always_comb begin
    state_n = state_q;
    ptr_n   = ptr_q;
    off_n   = off_q;
    clr_en  = 1'b0;
    case (state_q)
      RD_IDLE: begin
        if (occ[ptr_q]) begin
          state_n = RD_SEND;
          off_n   = '0;
        end
      end
      RD_SEND: begin
        if (m_tready) begin
          if (final_beat) begin
            state_n = RD_GAP;
          end else begin
            off_n = off_q + LEN_W'(DATA_BYTES);
          end
        end
      end
      RD_GAP: begin
        clr_en  = 1'b1;
        ptr_n   = ptr_inc;
        off_n   = '0;
        state_n = occ[ptr_inc] ? RD_SEND : RD_IDLE;
      end
      default: state_n = RD_IDLE;
    endcase
  end

  assign ptr_en = clr_en;
  assign off_en = (off_n != off_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RD_IDLE;
    end else begin
      state_q <= state_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '0;
    end else if (off_en) begin
      off_q <= off_n;
    end
  end

  assign rd_idx  = ptr_q;
  assign clr_idx = ptr_q;
  assign rd_addr = {ptr_q, off_q[LANE_W +: WORD_W]};

  for (genvar g = 0; g < DATA_BYTES; g++) begin : g_keep
    assign m_tkeep[g] = sending && (LEN_W'(g) < remaining);
  end

  assign m_tvalid = sending;
  assign m_tlast  = sending && final_beat;
  assign m_tdata  = sending ? rd_data : '0;
  assign m_tuser  = (sending && first_beat)
                  ? {rd_port, rd_port, LEN_FIELD_W'(rd_len)}
                  : '0;
endmodule

// File: rtl/pkt_slot_streamer.sv
`timescale 1ns/1ps
module pkt_slot_streamer
  import pss_pkg::*;
#(
  parameter int NUM_SLOTS  = 32,
  parameter int SLOT_BYTES = 2048,
  parameter int DATA_BYTES = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [7:0]              in_byte,
  input  logic                    in_last,
  input  logic [7:0]              in_port,
  output logic [DATA_BYTES*8-1:0] m_tdata,
  output logic [DATA_BYTES-1:0]   m_tkeep,
  output logic [31:0]             m_tuser,
  output logic                    m_tvalid,
  output logic                    m_tlast,
  input  logic                    m_tready
);
  localparam int PTR_W  = $clog2(NUM_SLOTS);
  localparam int LANE_W = $clog2(DATA_BYTES);
  localparam int WORD_W = $clog2(SLOT_BYTES / DATA_BYTES);
  localparam int ADDR_W = PTR_W + WORD_W;
  localparam int LEN_W  = $clog2(SLOT_BYTES + 1);
  localparam int BUS_W  = DATA_BYTES * 8;

  logic               rst_n_int;
  logic               wr_en, commit_en, clr_en;
  logic [ADDR_W-1:0]  wr_addr, rd_addr;
  logic [LANE_W-1:0]  wr_lane;
  logic [7:0]         wr_byte;
  logic [PTR_W-1:0]   commit_idx, clr_idx, rd_idx;
  logic [LEN_W-1:0]   commit_len, rd_len;
  logic [PORT_W-1:0]  commit_port, rd_port;
  logic [BUS_W-1:0]   rd_data;
  logic [NUM_SLOTS-1:0] occ;

  pss_reset_sync i_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  pss_slot_writer #(
    .NUM_SLOTS (NUM_SLOTS), .SLOT_BYTES (SLOT_BYTES), .DATA_BYTES (DATA_BYTES)
  ) i_writer (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .in_valid    (in_valid),
    .in_byte     (in_byte),
    .in_last     (in_last),
    .in_port     (in_port),
    .occ         (occ),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_lane     (wr_lane),
    .wr_byte     (wr_byte),
    .commit_en   (commit_en),
    .commit_idx  (commit_idx),
    .commit_len  (commit_len),
    .commit_port (commit_port)
  );

  pss_slot_store #(
    .NUM_SLOTS (NUM_SLOTS), .SLOT_BYTES (SLOT_BYTES), .DATA_BYTES (DATA_BYTES)
  ) i_store (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_lane     (wr_lane),
    .wr_byte     (wr_byte),
    .commit_en   (commit_en),
    .commit_idx  (commit_idx),
    .commit_len  (commit_len),
    .commit_port (commit_port),
    .clr_en      (clr_en),
    .clr_idx     (clr_idx),
    .rd_addr     (rd_addr),
    .rd_idx      (rd_idx),
    .rd_data     (rd_data),
    .rd_len      (rd_len),
    .rd_port     (rd_port),
    .occ         (occ)
  );

  pss_beat_reader #(
    .NUM_SLOTS (NUM_SLOTS), .SLOT_BYTES (SLOT_BYTES), .DATA_BYTES (DATA_BYTES)
  ) i_reader (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .occ      (occ),
    .rd_len   (rd_len),
    .rd_port  (rd_port),
    .rd_data  (rd_data),
    .rd_idx   (rd_idx),
    .rd_addr  (rd_addr),
    .clr_en   (clr_en),
    .clr_idx  (clr_idx),
    .m_tdata  (m_tdata),
    .m_tkeep  (m_tkeep),
    .m_tuser  (m_tuser),
    .m_tvalid (m_tvalid),
    .m_tlast  (m_tlast),
    .m_tready (m_tready)
  );
endmodule

// File: rtl/pss_stream_checker.sv
`timescale 1ns/1ps
module pss_stream_checker #(
  parameter int DATA_BYTES = 64
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [DATA_BYTES*8-1:0] m_tdata,
  input logic [DATA_BYTES-1:0]   m_tkeep,
  input logic [31:0]             m_tuser,
  input logic                    m_tvalid,
  input logic                    m_tlast,
  input logic                    m_tready
);
  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !m_tvalid |-> (m_tuser == '0 && !m_tlast && m_tkeep == '0));

  assert_later_user_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && m_tready && !m_tlast) |=> (m_tuser == '0));

  assert_hold_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tkeep)
                                 && $stable(m_tlast) && $stable(m_tuser)));

  assert_gap_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && m_tready && m_tlast) |=> !m_tvalid);

  assert_keep_from_lane0_R3: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> (m_tkeep[0] && ((m_tkeep & (m_tkeep + DATA_BYTES'(1))) == '0)));

  assert_keep_full_midpacket_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tlast) |-> (&m_tkeep));

  assert_dest_mirrors_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && m_tuser != '0) |-> (m_tuser[31:24] == m_tuser[23:16]));

  assert_first_beat_has_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_tvalid) |-> (m_tuser[15:0] != '0));
endmodule

bind pkt_slot_streamer pss_stream_checker #(.DATA_BYTES(DATA_BYTES)) i_stream_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .m_tdata  (m_tdata),
  .m_tkeep  (m_tkeep),
  .m_tuser  (m_tuser),
  .m_tvalid (m_tvalid),
  .m_tlast  (m_tlast),
  .m_tready (m_tready)
);

// File: tb/test_pkt_slot_streamer.sv
`timescale 1ns/1ps
module test_pkt_slot_streamer;
  localparam int NS = 4;
  localparam int SB = 64;
  localparam int DB = 8;

  logic          clk, rst_n;
  logic          in_valid, in_last;
  logic [7:0]    in_byte, in_port;
  logic [DB*8-1:0] m_tdata;
  logic [DB-1:0] m_tkeep;
  logic [31:0]   m_tuser;
  logic          m_tvalid, m_tlast, m_tready;

  pkt_slot_streamer #(.NUM_SLOTS(NS), .SLOT_BYTES(SB), .DATA_BYTES(DB)) i_pkt_slot_streamer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_last(in_last), .in_port(in_port), .m_tdata(m_tdata), .m_tkeep(m_tkeep),
    .m_tuser(m_tuser), .m_tvalid(m_tvalid), .m_tlast(m_tlast), .m_tready(m_tready)
  );

  typedef struct { int id; int len; int port; } pkt_t;
  pkt_t exp_q[$];

  int n_chk = 0;
  int n_fail = 0;
  int rdy_mode = 3;
  bit mon_en = 0;
  bit strict_gap = 0;
  bit done = 0;

  initial begin
    clk = 1'b0;
    forever #2.5 clk = ~clk;
  end

  function automatic logic [7:0] pat(int id, int i);
    return 8'((id * 37 + i * 11 + 5) & 255);
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // Receiver readiness, changed just after each rising edge.
  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    m_tready = 1'b0;
    forever begin
      @(posedge clk);
      #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (rdy_mode)
        0: m_tready = 1'b1;
        1: m_tready = ~m_tready;
        2: m_tready = lfsr[0];
        default: m_tready = 1'b0;
      endcase
    end
  end

  // Output monitor, sampling on the falling edge.
  initial begin
    int beat = 0;
    int gap_phase = 0;
    bit prev_hold = 0;
    logic [DB*8-1:0] sv_data;
    logic [DB-1:0] sv_keep;
    logic [31:0] sv_user;
    logic sv_last;
    forever begin
      @(negedge clk);
      if (mon_en) begin
        if (prev_hold)
          chk(m_tvalid && m_tdata == sv_data && m_tkeep == sv_keep && m_tuser == sv_user
              && m_tlast == sv_last, "R7 held beat changed", 64'(m_tuser), 64'(sv_user));
        if (gap_phase == 1) begin
          chk(!m_tvalid, "R8 no idle cycle after final beat", 64'(m_tvalid), 64'(0));
          gap_phase = (strict_gap && exp_q.size() > 0) ? 2 : 0;
        end else if (gap_phase == 2) begin
          chk(m_tvalid, "R8 next packet not after single gap", 64'(m_tvalid), 64'(1));
          gap_phase = 0;
        end
        if (m_tvalid) begin
          if (exp_q.size() == 0) begin
            chk(0, "R10 beat with no packet pending", 64'(m_tuser), 64'(0));
          end else begin
            pkt_t p;
            int rem, nb;
            bit data_ok;
            logic [DB-1:0] e_keep;
            logic [31:0] e_user;
            p = exp_q[0];
            rem = p.len - beat * DB;
            nb = (rem > DB) ? DB : rem;
            e_keep = DB'((1 << nb) - 1);
            e_user = (beat == 0) ? {8'(p.port), 8'(p.port), 16'(p.len)} : 32'd0;
            data_ok = 1;
            for (int i = 0; i < nb; i++)
              if (m_tdata[i*8 +: 8] != pat(p.id, beat * DB + i)) data_ok = 0;
            chk(data_ok, "R2 lane bytes", 64'(m_tdata), 64'(p.id));
            chk(m_tkeep == e_keep, "R3 keep mask", 64'(m_tkeep), 64'(e_keep));
            chk(m_tlast == (rem <= DB), "R4 last flag", 64'(m_tlast), 64'(rem <= DB));
            if (beat == 0) chk(m_tuser == e_user, "R5 first-beat metadata", 64'(m_tuser), 64'(e_user));
            else chk(m_tuser == '0, "R6 later beat metadata", 64'(m_tuser), 64'(0));
            if (m_tready) begin
              if (rem <= DB) begin
                void'(exp_q.pop_front());
                beat = 0;
                gap_phase = 1;
              end else begin
                beat++;
              end
            end
          end
        end else begin
          chk(m_tuser == '0 && !m_tlast && m_tkeep == '0, "R6 idle outputs", 64'(m_tuser), 64'(0));
        end
        prev_hold = m_tvalid && !m_tready;
        sv_data = m_tdata; sv_keep = m_tkeep; sv_user = m_tuser; sv_last = m_tlast;
      end
    end
  end

  task automatic send_pkt(int id, int len, int port);
    bit drop;
    pkt_t p;
    drop = (len > SB) || (exp_q.size() >= NS);
    if (!drop) begin
      p.id = id; p.len = len; p.port = port;
      exp_q.push_back(p);
    end
    for (int i = 0; i < len; i++) begin
      @(posedge clk);
      #1;
      in_valid = 1'b1;
      in_byte  = pat(id, i);
      in_last  = (i == len - 1);
      in_port  = 8'(port);
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic wait_room();
    while (exp_q.size() >= NS - 1) @(posedge clk);
  endtask

  task automatic drain(string tag);
    int t = 0;
    while ((exp_q.size() != 0 || m_tvalid) && t < 4000) begin
      @(posedge clk);
      t++;
    end
    repeat (4) @(posedge clk);
    chk(exp_q.size() == 0, tag, 64'(exp_q.size()), 64'(0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    report();
  end

  initial begin
    int id = 0;
    rst_n = 1'b0;
    in_valid = 1'b0; in_last = 1'b0; in_byte = '0; in_port = '0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(!m_tvalid && m_tuser == '0 && !m_tlast, "R1 outputs in reset", 64'(m_tvalid), 64'(0));
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(!m_tvalid && m_tuser == '0 && !m_tlast, "R1 outputs after release", 64'(m_tvalid), 64'(0));
    mon_en = 1;

    // R1: first packet after reset is played from slot 0.
    rdy_mode = 0;
    send_pkt(id, 9, 3); id++;
    drain("R1 first packet after reset not played");

    // R2 R3 R4 R5 R10: every length under three readiness patterns.
    for (int mode = 0; mode < 3; mode++) begin
      rdy_mode = mode;
      for (int len = 1; len <= SB; len++) begin
        wait_room();
        send_pkt(id, len, (id * 29) & 255);
        id++;
      end
      drain("R10 packets missing after sweep");
    end

    // R8: two stored packets, released together.
    for (int k = 0; k < 3; k++) begin
      rdy_mode = 3;
      repeat (2) @(posedge clk);
      send_pkt(id, (k == 0) ? 20 : (k == 1) ? 16 : 1, 200 + k); id++;
      send_pkt(id, (k == 2) ? 1 : 5 + k, 210 + k); id++;
      repeat (4) @(posedge clk);
      strict_gap = 1;
      rdy_mode = 0;
      drain("R8 back-to-back packets missing");
      strict_gap = 0;
    end

    // R9: fill the ring while stalled, then overflow it.
    rdy_mode = 3;
    repeat (2) @(posedge clk);
    for (int k = 0; k < NS + 2; k++) begin
      send_pkt(id, 3 + k * 5, 100 + k);
      id++;
    end
    chk(exp_q.size() == NS, "R9 bench model of accepted packets", 64'(exp_q.size()), 64'(NS));
    repeat (3) @(posedge clk);
    strict_gap = 1;
    rdy_mode = 0;
    drain("R9 stored packets not played after drop");
    strict_gap = 0;
    send_pkt(id, 7, 77); id++;
    drain("R9 write position moved on drop");

    // R11: oversize packets dropped, a full-slot packet kept.
    rdy_mode = 0;
    send_pkt(id, SB + 1, 11); id++;
    send_pkt(id, SB + 9, 12); id++;
    send_pkt(id, SB, 13); id++;
    drain("R11 full-slot packet missing after oversize drop");
    send_pkt(id, 2, 14); id++;
    drain("R11 write position moved on oversize drop");

    report();
  end
endmodule